// File: doc/BRIEF.md
# Floating-Point Control and Status Register Block

This block holds the two software-visible registers of a floating-point unit. The control word carries two trap enables and a rounding-mode field. The status word carries five sticky exception flags. Software reaches both registers through a single-cycle auxiliary read/write port: a write is captured on the clock edge, and read data is a combinational function of the address.

The arithmetic datapath connects on a side interface. It receives the current rounding mode, both as the raw field and as a one-hot decode, together with the two trap enables. It returns a per-cycle vector of exception pulses. Each pulse is ORed into the matching status flag, and the flag stays set until software clears it.

A status write changes the flags only when bit 31 of the written word is 1. When bit 31 is 0, the flags keep their value and change only through datapath events. A one-cycle trap request is raised when an invalid or divide-by-zero event arrives while its enable bit is set.

Top module: `fp_csr_block`

## Requirements
- R1: After reset, the control register reads 0x00000100 (round to nearest, both traps disabled), the status register reads 0, and trapReq is 0.
- R2: The control register is at auxiliary address 0x300 and the status register is at 0x301. Writes to any other address change nothing, and reads of any other address return 0.
- R3: Control bit 0 is the invalid-operation trap enable and control bit 1 is the divide-by-zero trap enable; trapEn[1:0] presents these two bits. Control bits [9:8] hold the rounding field. All other control bits read 0 and ignore writes.
- R4: roundMode equals the rounding field. roundOneHot has exactly one bit set: bit 0 for 00 (toward zero), bit 1 for 01 (to nearest), bit 2 for 10 (toward plus infinity) and bit 3 for 11 (toward minus infinity).
- R5: Status bits [4:0] are the flags invalid, divide-by-zero, overflow, underflow and inexact, from bit 0 upward. excEvent uses the same bit positions.
- R6: A write to 0x301 with bit 31 = 1 loads the flags from bits [4:0] of the data. A write to 0x301 with bit 31 = 0 leaves the flags unchanged.
- R7: Status bits [31:5] always read 0. Bit 31 is not stored.
- R8: Each excEvent bit sets its flag, and the flag stays set until a write to 0x301 with bit 31 = 1 clears it. When an event and an enabled status write fall in the same cycle, the event bits are ORed onto the written value.
- R9: trapReq is 1 for exactly the one cycle after a cycle in which excEvent[0] met trap enable bit 0, or excEvent[1] met trap enable bit 1. The enables used are the values held in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| auxAddr | input | 12 | Auxiliary register address |
| auxWrEn | input | 1 | Write strobe for auxWrData at auxAddr |
| auxWrData | input | 32 | Write data |
| auxRdData | output | 32 | Combinational read data for auxAddr |
| excEvent | input | 5 | Exception pulses from the datapath, one bit per flag |
| roundMode | output | 2 | Current rounding field |
| roundOneHot | output | 4 | One-hot decode of the rounding field |
| trapEn | output | 2 | Trap enables: bit 0 invalid, bit 1 divide-by-zero |
| trapReq | output | 1 | One-cycle trap request |

## Verification
The control register is swept over all 16 combinations of its four live bits, with every dead bit driven to 1. This separates field masking from decode errors in the rounding outputs. The status register is loaded with all 32 flag values, once with bit 31 set and once with it clear, which tells the write gate apart from the flag storage. Single-bit event pulses, accumulated one after another and then combined with same-cycle clearing writes, show whether flags are sticky and whether events take priority over writes. The full 4 × 32 grid of trap enables and event vectors separates correct enable matching from cross-wired or ungated trap logic, and writes to neighbouring addresses confirm the decode.

// File: rtl/fp_csr_pkg.sv
package fp_csr_pkg;
  localparam int ADDR_W   = 12;
  localparam int DATA_W   = 32;
  localparam int NFLAGS   = 5;
  localparam int NTRAPS   = 2;
  localparam int RM_LSB   = 8;
  localparam int RM_W     = 2;
  localparam int FWE_BIT  = DATA_W - 1;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = 12'h300;
  localparam logic [ADDR_W-1:0] STAT_ADDR = 12'h301;
  localparam logic [RM_W-1:0]   RM_RESET  = 2'b01;

  typedef struct packed {
    logic ctrlSel;   // address hits control
    logic statSel;   // address hits status
    logic ctrlWr;    // write control
    logic statLoad;  // enabled status load
  } csrStrobes_t;
endpackage

// File: rtl/fp_csr_decode.sv
module fp_csr_decode
  import fp_csr_pkg::*;
(
  input  logic [ADDR_W-1:0] auxAddr,
  input  logic              auxWrEn,
  input  logic              flagWriteBit,
  output csrStrobes_t       stb
);
  always_comb begin
    stb          = '0;
    stb.ctrlSel  = (auxAddr == CTRL_ADDR);
    stb.statSel  = (auxAddr == STAT_ADDR);
    stb.ctrlWr   = auxWrEn && stb.ctrlSel;
    stb.statLoad = auxWrEn && stb.statSel && flagWriteBit;
  end

  always_comb begin
    // R2: at most one register targeted
    a_r2_one_target: assert ($onehot0({stb.ctrlSel, stb.statSel}));
  end
endmodule

// File: rtl/fp_csr_regs.sv
module fp_csr_regs
  import fp_csr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  csrStrobes_t       stb,
  input  logic [DATA_W-1:0] auxWrData,
  input  logic [NFLAGS-1:0] excEvent,
  output logic [DATA_W-1:0] auxRdData,
  output logic [RM_W-1:0]   roundMode,
  output logic [(1<<RM_W)-1:0] roundOneHot,
  output logic [NTRAPS-1:0] trapEn,
  output logic              trapReq
);
  localparam int NMODES = 1 << RM_W;

  logic [NTRAPS-1:0] trapEnQ;
  logic [RM_W-1:0]   rmQ;
  logic [NFLAGS-1:0] flagsQ;
  logic [NFLAGS-1:0] flagsNext;
  logic              trapQ;
  logic              trapHit;

  assign flagsNext = (stb.statLoad ? auxWrData[NFLAGS-1:0] : flagsQ) | excEvent;
  assign trapHit   = |(excEvent[NTRAPS-1:0] & trapEnQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      trapEnQ <= '0;
      rmQ     <= RM_RESET;
      flagsQ  <= '0;
      trapQ   <= 1'b0;
    end else begin
      if (stb.ctrlWr) begin
        trapEnQ <= auxWrData[NTRAPS-1:0];
        rmQ     <= auxWrData[RM_LSB +: RM_W];
      end
      flagsQ <= flagsNext;
      trapQ  <= trapHit;
    end
  end

  always_comb begin
    auxRdData = '0;
    if (stb.ctrlSel) begin
      auxRdData[NTRAPS-1:0]     = trapEnQ;
      auxRdData[RM_LSB +: RM_W] = rmQ;
    end else if (stb.statSel) begin
      auxRdData[NFLAGS-1:0] = flagsQ;
    end
  end

  for (genvar m = 0; m < NMODES; m++) begin : g_rm
    assign roundOneHot[m] = (rmQ == RM_W'(m));
  end

  assign roundMode = rmQ;
  assign trapEn    = trapEnQ;
  assign trapReq   = trapQ;

  // R8: without an enabled load, no flag falls
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !$past(stb.statLoad) |-> ((flagsQ & $past(flagsQ)) == $past(flagsQ)));
  // R8: events always land in the flags
  a_r8_event_sets: assert property (@(posedge clk) disable iff (!rstN)
    |excEvent |=> ((flagsQ & $past(excEvent)) == $past(excEvent)));
  // R9: a matching event yields a request next cycle
  a_r9_trap_raise: assert property (@(posedge clk) disable iff (!rstN)
    (|(excEvent[NTRAPS-1:0] & trapEn)) |=> trapReq);
  // R9: no request without a matching event
  a_r9_trap_cause: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |-> $past(|(excEvent[NTRAPS-1:0] & trapEn)));
  // R4: decode is one-hot
  a_r4_rm_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $countones(roundOneHot) == 1);
  // R7: status upper bits read zero
  a_r7_stat_hi_zero: assert property (@(posedge clk) disable iff (!rstN)
    stb.statSel |-> (auxRdData[DATA_W-1:NFLAGS] == '0));
endmodule

// File: rtl/fp_csr_block.sv
module fp_csr_block
  import fp_csr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [11:0] auxAddr,
  input  logic        auxWrEn,
  input  logic [31:0] auxWrData,
  output logic [31:0] auxRdData,
  input  logic [4:0]  excEvent,
  output logic [1:0]  roundMode,
  output logic [3:0]  roundOneHot,
  output logic [1:0]  trapEn,
  output logic        trapReq
);
  csrStrobes_t stb;

  fp_csr_decode u_decode (
    .auxAddr      (auxAddr),
    .auxWrEn      (auxWrEn),
    .flagWriteBit (auxWrData[FWE_BIT]),
    .stb          (stb)
  );

  fp_csr_regs u_regs (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .auxWrData   (auxWrData),
    .excEvent    (excEvent),
    .auxRdData   (auxRdData),
    .roundMode   (roundMode),
    .roundOneHot (roundOneHot),
    .trapEn      (trapEn),
    .trapReq     (trapReq)
  );
endmodule

// File: tb/fp_csr_block_tb.sv
`timescale 1ns/1ps
module fp_csr_block_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] auxAddr = '0;
  logic        auxWrEn = 1'b0;
  logic [31:0] auxWrData = '0;
  logic [31:0] auxRdData;
  logic [4:0]  excEvent = '0;
  logic [1:0]  roundMode;
  logic [3:0]  roundOneHot;
  logic [1:0]  trapEn;
  logic        trapReq;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  fp_csr_block u_dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic auxWrite(input logic [11:0] a, input logic [31:0] d, input logic [4:0] ev);
    @(negedge clk);
    auxAddr = a; auxWrData = d; auxWrEn = 1'b1; excEvent = ev;
    @(negedge clk);
    auxWrEn = 1'b0; excEvent = '0;
  endtask

  task automatic auxRead(input logic [11:0] a, output logic [31:0] d);
    auxAddr = a;
    #1;
    d = auxRdData;
  endtask

  task automatic pulse(input logic [4:0] ev);
    @(negedge clk);
    excEvent = ev;
    @(negedge clk);
    excEvent = '0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [4:0]  acc;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    auxRead(12'h300, rd); check("R1 ctrl reset", rd, 32'h100);
    auxRead(12'h301, rd); check("R1 stat reset", rd, 32'h0);
    check("R1 trapReq reset", {31'b0, trapReq}, 32'h0);
    check("R4 reset roundOneHot", {28'b0, roundOneHot}, 32'h2);

    // R3 R4 control sweep, dead bits driven high
    for (int i = 0; i < 16; i++) begin
      logic [31:0] d;
      d = 32'hFFFF_FCFC | {22'b0, i[3:2], 6'b0, i[1:0]};
      auxWrite(12'h300, d, 5'b0);
      auxRead(12'h300, rd);
      check("R3 ctrl readback", rd, d & 32'h303);
      check("R3 trapEn", {30'b0, trapEn}, {30'b0, d[1:0]});
      check("R4 roundMode", {30'b0, roundMode}, {30'b0, d[9:8]});
      check("R4 roundOneHot", {28'b0, roundOneHot}, 32'h1 << d[9:8]);
    end
    auxWrite(12'h300, 32'h0, 5'b0);

    // R6 R7 enabled loads, dead bits high
    for (int v = 0; v < 32; v++) begin
      auxWrite(12'h301, 32'hFFFF_FFE0 | v, 5'b0);
      auxRead(12'h301, rd);
      check("R6 R7 stat load", rd, v);
      // R6 gated write leaves flags
      auxWrite(12'h301, 32'h0000_001F ^ v, 5'b0);
      auxRead(12'h301, rd);
      check("R6 gated write ignored", rd, v);
    end

    // R5 R8 sticky accumulation, one flag at a time
    auxWrite(12'h301, 32'h8000_0000, 5'b0);
    acc = '0;
    for (int b = 0; b < 5; b++) begin
      pulse(5'b1 << b);
      acc |= 5'b1 << b;
      auxRead(12'h301, rd);
      check("R5 R8 sticky flag", rd, {27'b0, acc});
    end
    // R8 event wins over same-cycle clear
    for (int v = 0; v < 32; v++) begin
      auxWrite(12'h301, 32'h8000_0000 | (v ^ 5'h15), v[4:0]);
      auxRead(12'h301, rd);
      check("R8 event with write", rd, {27'b0, v[4:0] | (v[4:0] ^ 5'h15)});
    end

    // R9 trap grid
    for (int e = 0; e < 4; e++) begin
      auxWrite(12'h300, {22'b0, 2'b01, 6'b0, e[1:0]}, 5'b0);
      for (int v = 0; v < 32; v++) begin
        logic expT;
        expT = |(v[1:0] & e[1:0]);
        @(negedge clk);
        excEvent = v[4:0];
        @(negedge clk);
        excEvent = '0;
        check("R9 trap request", {31'b0, trapReq}, {31'b0, expT});
        @(negedge clk);
        check("R9 trap one cycle", {31'b0, trapReq}, 32'h0);
      end
    end

    // R2 other addresses
    auxWrite(12'h300, 32'h0000_0203, 5'b0);
    auxWrite(12'h301, 32'h8000_0005, 5'b0);
    auxWrite(12'h302, 32'hFFFF_FFFF, 5'b0);
    auxWrite(12'h200, 32'h0000_0000, 5'b0);
    auxWrite(12'h701, 32'h8000_0000, 5'b0);
    auxRead(12'h300, rd); check("R2 ctrl untouched", rd, 32'h203);
    auxRead(12'h301, rd); check("R2 stat untouched", rd, 32'h5);
    auxRead(12'h302, rd); check("R2 unmapped read", rd, 32'h0);
    auxRead(12'h000, rd); check("R2 unmapped read low", rd, 32'h0);

    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule